// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns one 64-bit virtual address into a physical address together with the read, write and execute rights granted for it, or it returns a fault code. A request carries the virtual address, an access-mode index and a mask of the rights the access needs. The page table base is a separate, steadily held input. Mode values 4 to 7 bypass translation completely. Addresses in a sign-extended, kernel-only window are mapped directly. Every other address is resolved by walking a three-level table in memory.

The walk reads 64-bit table entries through a simple port: a one-cycle request pulse with an address, and a later one-cycle valid strobe with the data. Only one read is in flight at a time. An intermediate entry must be valid and must allow kernel reads. The leaf entry grants rights per mode, and its fault-on bits take rights away again. The walker stores no translations. It accepts a new request only while idle, and it raises `done` for a single cycle along with the result.

Top module: `ptw_walker`

## Requirements
- R1: During and directly after reset, `done`, `busy` and `mem_req` are low.
- R2: A mode value of 4 to 7 returns `res_paddr` equal to the virtual address, `res_prot` = 3'b111 and code 0, with no memory read. `done` is high in the cycle after the accepting edge. In `res_prot` and `req_need`, bit 0 is read, bit 1 is write and bit 2 is execute.
- R3: When bits 63:43 of the address are neither all zero nor all one, the result is code 1 (access violation), with no read, and `done` comes in the cycle after accept.
- R4: An address whose bits 63:43 are all one and whose bits 42:41 are 2'b10 is direct-mapped with no read. In mode 0 (kernel) the physical address takes bits 39:0 of the virtual address, its bit 43 equals virtual bit 40, all its other bits are zero, and the rights are 3'b111. Modes 1 to 3 get code 1.
- R5: A walk issues three reads, at base+idx*8. The indices are virtual bits 42:33, then 32:23, then 22:13. The first base is `pt_base`. Each following base is entry bits 63:32 shifted left by 13.
- R6: An entry with bit 0 (valid) clear at any level ends the walk with code 2 (not valid), and no further read is issued.
- R7: A first- or second-level entry with bit 8 (kernel read enable) clear ends the walk with code 1.
- R8: In the leaf entry, read and execute are granted by bit 8+mode and write by bit 12+mode. On success the physical address is (entry bits 63:32 << 13) | virtual bits 12:0.
- R9: If `req_need` is nonzero and none of the needed rights is granted by R8, the result is code 1.
- R10: Leaf bits 1, 2 and 3 remove read, write and execute respectively. If none of the needed rights survives, the code is 5 when execute was needed, otherwise 4 when write was needed, otherwise 3. When `req_need` is zero, a valid leaf always succeeds.
- R11: Any fault (code nonzero) returns `res_paddr` = 0 and `res_prot` = 0. `done` lasts exactly one cycle.
- R12: `mem_req` is a one-cycle pulse, and a new one comes only after the previous read's `mem_rvalid`. `req_valid` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a translation (taken only when idle) |
| req_vaddr | input | 64 | Virtual address |
| req_mode | input | 3 | 0 kernel, 1 executive, 2 supervisor, 3 user, 4-7 bypass |
| req_need | input | 3 | Needed rights: bit0 read, bit1 write, bit2 execute |
| pt_base | input | 64 | Physical base of the first-level table |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 64 | Read address |
| mem_rvalid | input | 1 | Read data valid, one cycle, at least one cycle after the request |
| mem_rdata | input | 64 | Table entry read |
| busy | output | 1 | A request is in progress |
| done | output | 1 | Result valid, one cycle |
| res_paddr | output | 64 | Physical address |
| res_prot | output | 3 | Granted rights: bit0 read, bit1 write, bit2 execute |
| res_code | output | 3 | 0 ok, 1 access violation, 2 not valid, 3 fault-on-read, 4 fault-on-write, 5 fault-on-execute |

## Verification
Bypass, out-of-range and direct-window results are due in the cycle after the accepting edge. The bench samples on falling edges and requires `done` at the first falling edge after accept. For a walk that makes k reads with a memory latency of L cycles after the request is seen, `done` is due at the 1 + k*(L+1)-th falling edge. The bench counts falling edges up to `done` and compares that count against this formula for every case, at more than one latency. The result fields are compared at that same edge, and the read addresses are logged by the memory model when each request is seen.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;
  localparam int DW    = 64;
  localparam int IDX_W = 10;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_L1   = 3'd1,
    ST_L2   = 3'd2,
    ST_L3   = 3'd3,
    ST_DONE = 3'd4
  } walk_st_t;

  typedef enum logic [2:0] {
    FC_NONE = 3'd0,
    FC_ACV  = 3'd1,
    FC_TNV  = 3'd2,
    FC_FOR  = 3'd3,
    FC_FOW  = 3'd4,
    FC_FOE  = 3'd5
  } fcode_t;

  // entry bit positions decoded by the walker
  localparam int B_VAL = 0;
  localparam int B_FO  = 1;   // three fault-on bits from here
  localparam int B_RE  = 8;   // four read enables, one per mode
  localparam int B_WE  = 12;  // four write enables, one per mode

  // address of one 8-byte slot in a table
  function automatic logic [DW-1:0] slot_addr(input logic [DW-1:0] base,
                                              input logic [IDX_W-1:0] idx);
    logic [DW-1:0] off;
    off = '0;
    off[IDX_W+2:3] = idx;
    return base + off;
  endfunction

  // base of the table or page named by an entry
  function automatic logic [DW-1:0] frame_of(input logic [DW-1:0] pte, input int pg_bits);
    logic [DW-1:0] pfn;
    pfn = {32'b0, pte[DW-1:32]};
    return pfn << pg_bits;
  endfunction

  // table index for level lvl (0 = first)
  function automatic logic [IDX_W-1:0] level_idx(input logic [DW-1:0] va,
                                                 input int pg_bits, input int lvl);
    logic [DW-1:0] s;
    s = va >> (pg_bits + IDX_W * (2 - lvl));
    return s[IDX_W-1:0];
  endfunction
endpackage

// File: rtl/ptw_region_decode.sv
`timescale 1ns/1ps
module ptw_region_decode
  import ptw_pkg::*;
#(
  parameter int VA_BITS = 43
) (
  input  logic [DW-1:0] va,
  output logic          range_bad,
  output logic          direct_hit,
  output logic [DW-1:0] direct_pa
);
  localparam int TOP_W  = DW - VA_BITS;
  localparam int WIN_LO = VA_BITS - 3;

  logic [TOP_W-1:0] top_bits;
  assign top_bits   = va[DW-1:VA_BITS];
  assign range_bad  = !((&top_bits) || (top_bits == '0));
  assign direct_hit = va[DW-1] && (va[VA_BITS-1 -: 2] == 2'b10);

  always_comb begin
    direct_pa = '0;
    direct_pa[WIN_LO-1:0] = va[WIN_LO-1:0];
    direct_pa[WIN_LO+3]   = va[WIN_LO];
  end
endmodule

// File: rtl/ptw_node_check.sv
`timescale 1ns/1ps
module ptw_node_check
  import ptw_pkg::*;
(
  input  logic   ent_valid,
  input  logic   ent_kread,
  output fcode_t code
);
  always_comb begin
    if (!ent_valid)      code = FC_TNV;
    else if (!ent_kread) code = FC_ACV;
    else                 code = FC_NONE;
  end
endmodule

// File: rtl/ptw_leaf_eval.sv
`timescale 1ns/1ps
module ptw_leaf_eval
  import ptw_pkg::*;
(
  input  logic       ent_valid,
  input  logic [2:0] ent_fo,     // fault-on read, write, execute
  input  logic [3:0] ent_re,     // read enable per mode
  input  logic [3:0] ent_we,     // write enable per mode
  input  logic [1:0] mode,
  input  logic [2:0] need,
  output logic [2:0] grant,
  output fcode_t     code
);
  logic       rd_en, wr_en;
  logic [2:0] raw;

  always_comb begin
    rd_en = ent_re[mode];
    wr_en = ent_we[mode];
    raw   = {rd_en, wr_en, rd_en};
    grant = raw & ~ent_fo;
    if (!ent_valid)                             code = FC_TNV;
    else if ((need != 3'b0) && ((raw & need) == 3'b0))   code = FC_ACV;
    else if ((need != 3'b0) && ((grant & need) == 3'b0)) begin
      if (need[2])      code = FC_FOE;
      else if (need[1]) code = FC_FOW;
      else              code = FC_FOR;
    end else                                    code = FC_NONE;
  end
endmodule

// File: rtl/ptw_walker.sv
`timescale 1ns/1ps
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int PG_BITS = 13,
  parameter int VA_BITS = 43
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [DW-1:0] req_vaddr,
  input  logic [2:0]    req_mode,
  input  logic [2:0]    req_need,
  input  logic [DW-1:0] pt_base,
  output logic          mem_req,
  output logic [DW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] res_paddr,
  output logic [2:0]    res_prot,
  output logic [2:0]    res_code
);
  localparam logic [DW-1:0] OFF_MASK = (DW'(1) << PG_BITS) - DW'(1);

  walk_st_t      st_q;
  logic          mem_req_q;
  logic [DW-1:0] mem_addr_q;
  logic [DW-1:0] va_q;
  logic [2:0]    mode_q;
  logic [2:0]    need_q;
  logic [DW-1:0] pa_q;
  logic [2:0]    prot_q;
  fcode_t        code_q;

  // named events
  logic acc_fire;
  logic rsp_take;
  logic fin_now;
  logic go_walk;
  logic step_next;
  logic [DW-1:0] fin_pa;
  logic [2:0]    fin_prot;
  fcode_t        fin_code;

  logic          rg_range_bad, rg_direct;
  logic [DW-1:0] rg_direct_pa;
  fcode_t        node_code;
  fcode_t        leaf_code;
  logic [2:0]    leaf_grant;

  assign acc_fire = req_valid && (st_q == ST_IDLE);
  assign rsp_take = mem_rvalid && !mem_req_q &&
                    ((st_q == ST_L1) || (st_q == ST_L2) || (st_q == ST_L3));

  ptw_region_decode #(.VA_BITS(VA_BITS)) u_region (
    .va         (req_vaddr),
    .range_bad  (rg_range_bad),
    .direct_hit (rg_direct),
    .direct_pa  (rg_direct_pa)
  );

  ptw_node_check u_node (
    .ent_valid (mem_rdata[B_VAL]),
    .ent_kread (mem_rdata[B_RE]),
    .code      (node_code)
  );

  ptw_leaf_eval u_leaf (
    .ent_valid (mem_rdata[B_VAL]),
    .ent_fo    (mem_rdata[B_FO +: 3]),
    .ent_re    (mem_rdata[B_RE +: 4]),
    .ent_we    (mem_rdata[B_WE +: 4]),
    .mode      (mode_q[1:0]),
    .need      (need_q),
    .grant     (leaf_grant),
    .code      (leaf_code)
  );

  always_comb begin
    fin_now   = 1'b0;
    fin_pa    = '0;
    fin_prot  = 3'b000;
    fin_code  = FC_NONE;
    go_walk   = 1'b0;
    step_next = 1'b0;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        if (req_mode[2]) begin
          fin_now  = 1'b1;
          fin_pa   = req_vaddr;
          fin_prot = 3'b111;
        end else if (rg_range_bad) begin
          fin_now  = 1'b1;
          fin_code = FC_ACV;
        end else if (rg_direct) begin
          fin_now = 1'b1;
          if (req_mode == 3'd0) begin
            fin_pa   = rg_direct_pa;
            fin_prot = 3'b111;
          end else begin
            fin_code = FC_ACV;
          end
        end else begin
          go_walk = 1'b1;
        end
      end
      ST_L1, ST_L2: if (rsp_take) begin
        if (node_code != FC_NONE) begin
          fin_now  = 1'b1;
          fin_code = node_code;
        end else begin
          step_next = 1'b1;
        end
      end
      ST_L3: if (rsp_take) begin
        fin_now  = 1'b1;
        fin_code = leaf_code;
        if (leaf_code == FC_NONE) begin
          fin_pa   = frame_of(mem_rdata, PG_BITS) | (va_q & OFF_MASK);
          fin_prot = leaf_grant;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      mem_req_q  <= 1'b0;
      mem_addr_q <= '0;
      va_q       <= '0;
      mode_q     <= 3'd0;
      need_q     <= 3'd0;
      pa_q       <= '0;
      prot_q     <= 3'd0;
      code_q     <= FC_NONE;
    end else begin
      mem_req_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (acc_fire) begin
          va_q   <= req_vaddr;
          mode_q <= req_mode;
          need_q <= req_need;
          if (go_walk) begin
            st_q       <= ST_L1;
            mem_req_q  <= 1'b1;
            mem_addr_q <= slot_addr(pt_base, level_idx(req_vaddr, PG_BITS, 0));
          end
        end
        ST_L1, ST_L2: if (step_next) begin
          st_q       <= (st_q == ST_L1) ? ST_L2 : ST_L3;
          mem_req_q  <= 1'b1;
          mem_addr_q <= slot_addr(frame_of(mem_rdata, PG_BITS),
                                  level_idx(va_q, PG_BITS, (st_q == ST_L1) ? 1 : 2));
        end
        ST_DONE: st_q <= ST_IDLE;
        default: ;
      endcase
      if (fin_now) begin
        st_q   <= ST_DONE;
        pa_q   <= fin_pa;
        prot_q <= fin_prot;
        code_q <= fin_code;
      end
    end
  end

  logic unused_bits;
  assign unused_bits = ^{mem_rdata[31:16], mem_rdata[7:4], mode_q[2]};

  assign mem_req   = mem_req_q;
  assign mem_addr  = mem_addr_q;
  assign busy      = (st_q != ST_IDLE);
  assign done      = (st_q == ST_DONE);
  assign res_paddr = pa_q;
  assign res_prot  = prot_q;
  assign res_code  = code_q;
endmodule

// File: rtl/ptw_walker_chk.sv
`timescale 1ns/1ps
module ptw_walker_chk #(
  parameter int VA_BITS = 43
) (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_fire,
  input logic [63:0] req_vaddr,
  input logic [2:0]  req_mode,
  input logic [2:0]  req_need,
  input logic        busy,
  input logic        done,
  input logic        mem_req,
  input logic [63:0] res_paddr,
  input logic [2:0]  res_prot,
  input logic [2:0]  res_code
);
  logic [63:0] cap_va;
  logic [2:0]  cap_mode;
  logic [2:0]  cap_need;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_va   <= '0;
      cap_mode <= 3'd0;
      cap_need <= 3'd0;
    end else if (acc_fire) begin
      cap_va   <= req_vaddr;
      cap_mode <= req_mode;
      cap_need <= req_need;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !done && !mem_req);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12
  one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R12
  read_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  // R11
  fault_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_code != 3'd0) |-> (res_paddr == 64'd0 && res_prot == 3'd0));

  // R2
  bypass_ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_mode[2]) |-> (res_paddr == cap_va && res_prot == 3'b111 && res_code == 3'd0));

  // R2
  bypass_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && req_mode[2]) |=> (done && !mem_req));

  // R9
  grant_need_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_code == 3'd0 && cap_need != 3'd0) |-> ((res_prot & cap_need) != 3'd0));

  // R4
  direct_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cap_mode[2] && cap_mode != 3'd0 && (&cap_va[63:VA_BITS]) &&
     cap_va[VA_BITS-1 -: 2] == 2'b10) |-> (res_code == 3'd1));
endmodule

bind ptw_walker ptw_walker_chk #(.VA_BITS(VA_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_fire  (acc_fire),
  .req_vaddr (req_vaddr),
  .req_mode  (req_mode),
  .req_need  (req_need),
  .busy      (busy),
  .done      (done),
  .mem_req   (mem_req),
  .res_paddr (res_paddr),
  .res_prot  (res_prot),
  .res_code  (res_code)
);

// File: tb/tb_ptw_walker.sv
`timescale 1ns/1ps
module tb_ptw_walker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [63:0] req_vaddr;
  logic [2:0]  req_mode, req_need;
  logic [63:0] pt_base;
  logic        mem_req, mem_rvalid;
  logic [63:0] mem_addr, mem_rdata;
  logic        busy, done;
  logic [63:0] res_paddr;
  logic [2:0]  res_prot, res_code;

  always #2.5 clk = ~clk;

  ptw_walker dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_mode(req_mode), .req_need(req_need), .pt_base(pt_base),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .res_paddr(res_paddr), .res_prot(res_prot), .res_code(res_code)
  );

  localparam logic [63:0] E_V = 64'h1, E_FR = 64'h2, E_FW = 64'h4, E_FX = 64'h8;
  localparam logic [63:0] E_KR = 64'h100, E_ER = 64'h200, E_UR = 64'h800;
  localparam logic [63:0] E_KW = 64'h1000, E_UW = 64'h8000;
  localparam logic [63:0] VA0 = 64'h0000_0006_0280_E123;
  localparam logic [63:0] A_L1 = 64'h10_0018, A_L2 = 64'h40_0028, A_L3 = 64'h60_0038;

  logic [63:0] pmem [logic [63:0]];
  logic [63:0] rd_log [8];
  int lat = 1;
  int nrd = 0;
  int n_chk = 0, n_bad = 0;

  function automatic logic [63:0] rd(input logic [63:0] a);
    return pmem.exists(a) ? pmem[a] : 64'h0;
  endfunction

  // memory model: sees a request at a falling edge, answers lat falling edges later
  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = 64'h0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (mem_req) begin
        logic [63:0] a;
        a = mem_addr;
        if (nrd < 8) rd_log[nrd] = a;
        nrd++;
        repeat (lat) @(negedge clk);
        mem_rvalid = 1'b1;
        mem_rdata  = rd(a);
      end
    end
  end

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // bench's own restatement of the translation rules
  function automatic void model(input logic [63:0] va, input logic [2:0] mode, input logic [2:0] need,
                                output logic [63:0] pa, output logic [2:0] pr,
                                output int code, output int reads);
    logic [63:0] base, e;
    logic [20:0] hi;
    logic [2:0]  raw, msk;
    logic        r, w;
    pa = 64'h0; pr = 3'd0; code = 0; reads = 0; e = 64'h0;
    hi = va[63:43];
    if (mode >= 3'd4) begin pa = va; pr = 3'd7; return; end
    if (!(hi == 21'h0 || hi == 21'h1F_FFFF)) begin code = 1; return; end
    if (va[63] && va[42] && !va[41]) begin
      if (mode == 3'd0) begin pa = {20'h0, va[40], 3'b000, va[39:0]}; pr = 3'd7; end
      else code = 1;
      return;
    end
    base = pt_base;
    for (int lv = 0; lv < 3; lv++) begin
      e = rd(base + (((va / 64'd8192) >> (10 * (2 - lv))) % 64'd1024) * 64'd8);
      reads++;
      if (!e[0]) begin code = 2; return; end
      if (lv < 2 && !e[8]) begin code = 1; return; end
      base = (e >> 32) * 64'd8192;
    end
    r = e[8 + mode];
    w = e[12 + mode];
    raw = {r, w, r};
    if (need != 3'd0 && (raw & need) == 3'd0) begin code = 1; return; end
    msk = raw & ~e[3:1];
    if (need != 3'd0 && (msk & need) == 3'd0) begin
      code = need[2] ? 5 : (need[1] ? 4 : 3);
      return;
    end
    pa = base | (va % 64'd8192);
    pr = msk;
  endfunction

  task automatic run(input logic [63:0] va, input logic [2:0] mode, input logic [2:0] need,
                     output int cyc);
    @(negedge clk);
    nrd = 0;
    req_valid = 1'b1; req_vaddr = va; req_mode = mode; req_need = need;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic case_chk(input string tag, input logic [63:0] va, input logic [2:0] mode,
                          input logic [2:0] need);
    logic [63:0] xpa;
    logic [2:0]  xpr;
    int xc, xr, cyc;
    model(va, mode, need, xpa, xpr, xc, xr);
    run(va, mode, need, cyc);
    chk({tag, " paddr"}, res_paddr, xpa);
    chk({tag, " prot"}, {61'd0, res_prot}, {61'd0, xpr});
    chk({tag, " code"}, {61'd0, res_code}, 64'(xc));
    chk({tag, " reads"}, 64'(nrd), 64'(xr));
    chk({tag, " latency"}, 64'(cyc), 64'(1 + xr * (lat + 1)));
  endtask

  task automatic set_tables();
    pmem.delete();
    pmem[A_L1] = (64'h200 << 32) | E_V | E_KR;
    pmem[A_L2] = (64'h300 << 32) | E_V | E_KR;
    pmem[A_L3] = (64'hABCD << 32) | E_V | E_KR | E_KW;
  endtask

  task automatic set_leaf(input logic [63:0] flags);
    pmem[A_L3] = (64'hABCD << 32) | flags;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_mode = '0; req_need = '0;
    pt_base = 64'h10_0000;
    repeat (3) @(negedge clk);
    chk("R1 done in reset", {63'd0, done}, 64'd0);
    chk("R1 busy in reset", {63'd0, busy}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mem_req after reset", {63'd0, mem_req}, 64'd0);
    chk("R1 done after reset", {63'd0, done}, 64'd0);
  endtask

  task automatic t_bypass();
    case_chk("R2 bypass m4", 64'h0123_4567_89AB_CDEF, 3'd4, 3'd2);
    case_chk("R2 bypass m7", 64'hFFFF_FD00_0000_0040, 3'd7, 3'd4);
  endtask

  task automatic t_range();
    case_chk("R3 range hi", 64'h0100_0000_0000_0000, 3'd0, 3'd1);
    case_chk("R3 range bit43", 64'hFFFF_F000_0000_0000, 3'd0, 3'd1);
  endtask

  task automatic t_direct();
    int cyc;
    run(64'hFFFF_FD12_3456_789A, 3'd0, 3'd1, cyc);
    chk("R4 direct paddr", res_paddr, 64'h0000_0812_3456_789A);
    chk("R4 direct prot", {61'd0, res_prot}, 64'd7);
    chk("R4 direct cycle", 64'(cyc), 64'd1);
    case_chk("R4 direct b40 clear", 64'hFFFF_FC00_0000_0010, 3'd0, 3'd2);
    case_chk("R4 direct exec mode", 64'hFFFF_FD12_3456_789A, 3'd1, 3'd1);
    case_chk("R4 direct user mode", 64'hFFFF_FD12_3456_789A, 3'd3, 3'd1);
  endtask

  task automatic t_walk();
    int cyc;
    set_tables();
    lat = 1;
    run(VA0, 3'd0, 3'd1, cyc);
    chk("R8 walk paddr", res_paddr, 64'h0000_0000_1579_A123);
    chk("R8 walk prot", {61'd0, res_prot}, 64'd7);
    chk("R5 walk code", {61'd0, res_code}, 64'd0);
    chk("R5 read count", 64'(nrd), 64'd3);
    chk("R5 first addr", rd_log[0], A_L1);
    chk("R5 second addr", rd_log[1], A_L2);
    chk("R5 third addr", rd_log[2], A_L3);
    chk("R12 walk latency", 64'(cyc), 64'd7);
    lat = 3;
    case_chk("R5 walk slow mem", VA0, 3'd0, 3'd3);
    lat = 1;
  endtask

  task automatic t_modes();
    set_tables();
    set_leaf(E_V | E_UR | E_UW);
    case_chk("R8 user rw", VA0, 3'd3, 3'd2);
    set_leaf(E_V | E_ER);
    case_chk("R8 exec-mode read only", VA0, 3'd1, 3'd4);
    set_leaf(E_V | E_KR | E_KW);
    case_chk("R9 user none granted", VA0, 3'd3, 3'd1);
    set_leaf(E_V | E_KR);
    case_chk("R9 kernel write denied", VA0, 3'd0, 3'd2);
  endtask

  task automatic t_fault_on();
    set_tables();
    set_leaf(E_V | E_KR | E_KW | E_FW);
    case_chk("R10 fault-on-write", VA0, 3'd0, 3'd2);
    set_leaf(E_V | E_KR | E_KW | E_FW | E_FX);
    case_chk("R10 exec wins", VA0, 3'd0, 3'd6);
    set_leaf(E_V | E_KR | E_FR);
    case_chk("R10 fault-on-read", VA0, 3'd0, 3'd1);
    set_leaf(E_V | E_KR | E_KW | E_FR);
    case_chk("R10 partial keep", VA0, 3'd0, 3'd3);
    set_leaf(E_V | E_KR | E_KW | E_FR | E_FW | E_FX);
    case_chk("R10 need none", VA0, 3'd0, 3'd0);
  endtask

  task automatic t_walk_faults();
    set_tables();
    pmem[A_L2] = 64'h300 << 32;
    case_chk("R6 invalid second", VA0, 3'd0, 3'd1);
    set_tables();
    set_leaf(E_KR | E_KW);
    case_chk("R6 invalid leaf", VA0, 3'd0, 3'd1);
    set_tables();
    pmem[A_L1] = (64'h200 << 32) | E_V;
    case_chk("R7 first no kread", VA0, 3'd3, 3'd1);
    set_tables();
    pmem[A_L2] = (64'h300 << 32) | E_V | E_UR;
    case_chk("R7 second no kread", VA0, 3'd0, 3'd1);
    chk("R11 fault paddr zero", res_paddr, 64'd0);
  endtask

  task automatic t_busy_ignore();
    int cyc;
    set_tables();
    lat = 4;
    @(negedge clk);
    nrd = 0;
    req_valid = 1'b1; req_vaddr = VA0; req_mode = 3'd0; req_need = 3'd1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 64'h0000_0000_0000_0777; req_mode = 3'd4; req_need = 3'd1;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!done && cyc < 200) begin @(negedge clk); cyc++; end
    chk("R12 ignored while busy paddr", res_paddr, 64'h0000_0000_1579_A123);
    chk("R12 ignored while busy reads", 64'(nrd), 64'd3);
    @(negedge clk);
    chk("R11 done one cycle", {63'd0, done}, 64'd0);
    @(negedge clk);
    chk("R12 no late second result", {63'd0, done}, 64'd0);
    lat = 1;
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_range();
    t_direct();
    t_walk();
    t_modes();
    t_fault_on();
    t_walk_faults();
    t_busy_ignore();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule